// File: doc/BRIEF.md
# UART Receiver Wakeup Controller

This block decides when a sleeping UART receiver wakes up. Software puts the receiver to sleep with a one-cycle set pulse. While the receiver sleeps, the characters it receives are withheld from the receive buffer. The block clears the sleep flag again when the selected wakeup condition occurs.

The block does not sample the serial line itself. It watches a bit-level event stream from the receive datapath:

- a start-bit strobe;
- one strobe per sampled data bit, carrying the bit's index and value;
- a stop-bit strobe;
- a tick for each bit time of high line between characters.

From this stream it builds the character, counts idle bit times and evaluates three wakeup modes:

- **Idle-line:** the idle count can start at one of two points.
- **Address-mark:** the receiver wakes partway through the character, on its MSB.
- **Data-match:** the character is compared against two enabled match values.

A delivery strobe, with the assembled character, tells the receive buffer when a character is to be written.

Top module: `uart_rx_wakeup`

## Requirements
- R1: After reset `sleep_o`, `idle_o` and `deliver_o` are 0.
- R2: With `ilt_i`=0, idle is counted from the first data bit. Every data bit of value 1, the stop strobe and every idle tick add one to the count. A data bit of value 0 restarts the count at zero. `idle_o` pulses for one cycle, after the edge of the event that brings the count to the character length (data bits + 2).
- R3: With `ilt_i`=1, data bits and the stop bit do not count. `idle_o` pulses after the edge of the (data bits + 2)-th idle tick that follows the stop strobe.
- R4: `idle_o` pulses at most once per idle period. It cannot pulse again until a start strobe has been seen.
- R5: A `sleep_set_i` pulse makes `sleep_o` 1 from the next cycle. When a set pulse and a wakeup condition fall in the same cycle, the set wins.
- R6: Idle-line mode applies when `match_cfg_i`≠2'b11 and `wake_sel_i`=0. In this mode a sleeping receiver clears `sleep_o` on the same edge that raises `idle_o`.
- R7: Address-mark mode applies when `match_cfg_i`≠2'b11 and `wake_sel_i`=1. In this mode `sleep_o` clears on the edge that samples the MSB data bit (index 8 in 9-bit mode, 7 in 8-bit mode) with value 1. This happens before the stop strobe. Idle detection does not wake the receiver in this mode.
- R8: A character that wakes the receiver by address-mark is itself delivered at its stop strobe.
- R9: When `match_cfg_i`=2'b11, data-match mode applies whatever `wake_sel_i` is.
  - At the stop strobe the character is compared with `match1_i` (only if `match_en1_i`=1) and with `match2_i` (only if `match_en2_i`=1).
  - On a match, `sleep_o` clears and the character is delivered.
  - An idle period or an MSB of value 1 does not wake the receiver in this mode.
- R10: While `sleep_o` is 1 and no wakeup condition occurs in a character, that character is not delivered.
- R11: An awake receiver pulses `deliver_o` one cycle after each stop strobe. `rx_data_o` bit i then holds the data bit with index i, and bit 8 reads 0 in 8-bit mode.
- R12: `nine_bit_i`=1 selects 9 data bits and `nine_bit_i`=0 selects 8. In 8-bit mode bit 8 of the match values is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start bit detected (strobe) |
| bit_vld_i | input | 1 | Data bit sampled (strobe) |
| bit_idx_i | input | 4 | Index of the sampled data bit |
| bit_val_i | input | 1 | Value of the sampled data bit |
| stop_i | input | 1 | Stop bit time (strobe) |
| idle_tick_i | input | 1 | One bit time of high line outside a character |
| ilt_i | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| wake_sel_i | input | 1 | Wakeup method: 0 idle-line, 1 address-mark |
| match_cfg_i | input | 2 | 2'b11 selects data-match wakeup |
| match_en1_i | input | 1 | Enable for match value 1 |
| match_en2_i | input | 1 | Enable for match value 2 |
| match1_i | input | 9 | Match value 1 |
| match2_i | input | 9 | Match value 2 |
| nine_bit_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| sleep_set_i | input | 1 | Set the sleep flag (one-cycle pulse) |
| sleep_o | output | 1 | Receiver sleep flag |
| idle_o | output | 1 | Idle line detected (one-cycle pulse) |
| deliver_o | output | 1 | Write the character to the receive buffer (strobe) |
| rx_data_o | output | 9 | Delivered character |

## Verification
The assertions rely on the following properties of the input stream:

- At most one of the start, data-bit, stop and idle-tick strobes is active in any cycle.
- The data bits of a character arrive between its start and stop strobes, with indices below the configured width.
- Configuration inputs only change while no character or idle period is in flight.

The stimulus keeps within these limits by driving every event from a task that raises exactly one strobe for one cycle. Only one test drives two strobes together: it raises the sleep set pulse in the same cycle as the completing idle tick. Configuration changes are made only between sweeps.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_sel_e;

  localparam logic [1:0] MCFG_DATA_MATCH = 2'b11;
endpackage

// File: rtl/uart_wake_idle_cnt.sv
module uart_wake_idle_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bit_vld_i,
  input  logic             bit_val_i,
  input  logic             stop_i,
  input  logic             idle_tick_i,
  input  logic             ilt_i,
  input  logic [CNT_W-1:0] char_len_i,
  output logic             idle_hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q, done_q;
  logic             inc, clr;

  // arm_q: counting enabled; stays low from start to stop when ilt_i=1
  always_comb begin
    inc = arm_q & ((bit_vld_i & bit_val_i) | stop_i | idle_tick_i);
    clr = arm_q & bit_vld_i & ~bit_val_i;
  end

  assign idle_hit_o = inc & ~done_q & ~start_i & (cnt_q == char_len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      arm_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      arm_q  <= ~ilt_i;
      done_q <= 1'b0;
    end else begin
      if (stop_i) arm_q <= 1'b1;
      if (clr) cnt_q <= '0;
      else if (inc && !done_q) cnt_q <= cnt_q + 1'b1;
      if (idle_hit_o) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_wake_char_asm.sv
module uart_wake_char_asm #(
  parameter int DATA_W = 9,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bit_vld_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  input  logic              nine_bit_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] MASK_S = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else if (start_i) shreg_q <= '0;
    else if (bit_vld_i && (int'(bit_idx_i) < DATA_W)) shreg_q[bit_idx_i] <= bit_val_i;
  end

  assign data_o = nine_bit_i ? shreg_q : (shreg_q & MASK_S);
endmodule

// File: rtl/uart_wake_match.sv
module uart_wake_match #(
  parameter int DATA_W = 9
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] match1_i,
  input  logic [DATA_W-1:0] match2_i,
  input  logic              en1_i,
  input  logic              en2_i,
  input  logic              nine_bit_i,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] MASK_S = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] mask;
  logic              hit1, hit2;

  always_comb begin
    mask  = nine_bit_i ? '1 : MASK_S;
    hit1  = en1_i & ((data_i & mask) == (match1_i & mask));
    hit2  = en2_i & ((data_i & mask) == (match2_i & mask));
    hit_o = hit1 | hit2;
  end
endmodule

// File: rtl/uart_rx_wakeup.sv
module uart_rx_wakeup
  import uart_wake_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bit_vld_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  input  logic              stop_i,
  input  logic              idle_tick_i,
  input  logic              ilt_i,
  input  logic              wake_sel_i,
  input  logic [1:0]        match_cfg_i,
  input  logic              match_en1_i,
  input  logic              match_en2_i,
  input  logic [DATA_W-1:0] match1_i,
  input  logic [DATA_W-1:0] match2_i,
  input  logic              nine_bit_i,
  input  logic              sleep_set_i,
  output logic              sleep_o,
  output logic              idle_o,
  output logic              deliver_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam logic [CNT_W-1:0] LEN_L = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_S = CNT_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] MSB_L = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] MSB_S = IDX_W'(DATA_W - 2);

  logic [CNT_W-1:0]  char_len;
  logic [IDX_W-1:0]  msb_idx;
  logic [DATA_W-1:0] char_data;
  logic              idle_hit, match_hit;
  logic              mode_dm, mode_am, mode_il;
  logic              wake_il, wake_am, wake_dm;
  logic              sleep_q, deliver_d;

  assign char_len = nine_bit_i ? LEN_L : LEN_S;
  assign msb_idx  = nine_bit_i ? MSB_L : MSB_S;

  uart_wake_idle_cnt #(.CNT_W(CNT_W)) i_idle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bit_vld_i   (bit_vld_i),
    .bit_val_i   (bit_val_i),
    .stop_i      (stop_i),
    .idle_tick_i (idle_tick_i),
    .ilt_i       (ilt_i),
    .char_len_i  (char_len),
    .idle_hit_o  (idle_hit)
  );

  uart_wake_char_asm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bit_vld_i  (bit_vld_i),
    .bit_idx_i  (bit_idx_i),
    .bit_val_i  (bit_val_i),
    .nine_bit_i (nine_bit_i),
    .data_o     (char_data)
  );

  uart_wake_match #(.DATA_W(DATA_W)) i_match (
    .data_i     (char_data),
    .match1_i   (match1_i),
    .match2_i   (match2_i),
    .en1_i      (match_en1_i),
    .en2_i      (match_en2_i),
    .nine_bit_i (nine_bit_i),
    .hit_o      (match_hit)
  );

  // data-match configuration overrides the wakeup method select
  always_comb begin
    mode_dm   = (match_cfg_i == MCFG_DATA_MATCH);
    mode_am   = ~mode_dm & (wake_sel_i == WAKE_ADDR);
    mode_il   = ~mode_dm & (wake_sel_i == WAKE_IDLE);
    wake_il   = sleep_q & mode_il & idle_hit;
    wake_am   = sleep_q & mode_am & bit_vld_i & bit_val_i & (bit_idx_i == msb_idx);
    wake_dm   = sleep_q & mode_dm & stop_i & match_hit;
    deliver_d = stop_i & (~sleep_q | wake_dm);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q   <= 1'b0;
      idle_o    <= 1'b0;
      deliver_o <= 1'b0;
      rx_data_o <= '0;
    end else begin
      if (sleep_set_i) sleep_q <= 1'b1;
      else if (wake_il || wake_am || wake_dm) sleep_q <= 1'b0;
      idle_o    <= idle_hit;
      deliver_o <= deliver_d;
      if (deliver_d) rx_data_o <= char_data;
    end
  end

  assign sleep_o = sleep_q;
endmodule

// File: rtl/uart_rx_wakeup_chk.sv
module uart_rx_wakeup_chk #(
  parameter int DATA_W = 9,
  parameter int IDX_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_vld_i,
  input logic [IDX_W-1:0] bit_idx_i,
  input logic             bit_val_i,
  input logic             wake_sel_i,
  input logic [1:0]       match_cfg_i,
  input logic             nine_bit_i,
  input logic             sleep_set_i,
  input logic             sleep_o,
  input logic             idle_o,
  input logic             deliver_o
);
  logic [IDX_W-1:0] msb_idx;
  assign msb_idx = nine_bit_i ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);

  AST_IDLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> !idle_o); // R4

  AST_SET_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_set_i |=> sleep_o); // R5

  AST_SLEEP_ONLY_BY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(sleep_set_i)); // R5

  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !$past(sleep_set_i) && match_cfg_i != 2'b11 && !wake_sel_i) |-> !sleep_o); // R6

  AST_AMARK_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !sleep_set_i && match_cfg_i != 2'b11 && wake_sel_i &&
     bit_vld_i && bit_val_i && bit_idx_i == msb_idx) |=> !sleep_o); // R7

  AST_ASLEEP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> (!sleep_o || $past(sleep_set_i))); // R10
endmodule

bind uart_rx_wakeup uart_rx_wakeup_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_vld_i   (bit_vld_i),
  .bit_idx_i   (bit_idx_i),
  .bit_val_i   (bit_val_i),
  .wake_sel_i  (wake_sel_i),
  .match_cfg_i (match_cfg_i),
  .nine_bit_i  (nine_bit_i),
  .sleep_set_i (sleep_set_i),
  .sleep_o     (sleep_o),
  .idle_o      (idle_o),
  .deliver_o   (deliver_o)
);

// File: tb/test_uart_rx_wakeup.sv
`timescale 1ns/1ps
module test_uart_rx_wakeup;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       start_i, bit_vld_i, bit_val_i, stop_i, idle_tick_i;
  logic [3:0] bit_idx_i;
  logic       ilt_i, wake_sel_i, match_en1_i, match_en2_i, nine_bit_i, sleep_set_i;
  logic [1:0] match_cfg_i;
  logic [8:0] match1_i, match2_i;
  logic       sleep_o, idle_o, deliver_o;
  logic [8:0] rx_data_o;

  always #4 clk = ~clk;

  uart_rx_wakeup i_uart_rx_wakeup (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bit_vld_i   (bit_vld_i),
    .bit_idx_i   (bit_idx_i),
    .bit_val_i   (bit_val_i),
    .stop_i      (stop_i),
    .idle_tick_i (idle_tick_i),
    .ilt_i       (ilt_i),
    .wake_sel_i  (wake_sel_i),
    .match_cfg_i (match_cfg_i),
    .match_en1_i (match_en1_i),
    .match_en2_i (match_en2_i),
    .match1_i    (match1_i),
    .match2_i    (match2_i),
    .nine_bit_i  (nine_bit_i),
    .sleep_set_i (sleep_set_i),
    .sleep_o     (sleep_o),
    .idle_o      (idle_o),
    .deliver_o   (deliver_o),
    .rx_data_o   (rx_data_o)
  );

  int   total = 0, bad = 0;
  int   idle_n, dlv_n, idle_at, tick_no, nb;
  int   dlv_data;
  bit   fin = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic sample();
    if (idle_o) begin idle_n++; idle_at = tick_no; end
    if (deliver_o) begin dlv_n++; dlv_data = int'(rx_data_o); end
  endtask

  task automatic clr_mon();
    idle_n = 0; dlv_n = 0; idle_at = -1; tick_no = 0; dlv_data = -1;
  endtask

  task automatic t_start();
    start_i = 1; @(negedge clk); start_i = 0; sample();
  endtask

  task automatic t_bit(int i, bit v);
    bit_vld_i = 1; bit_idx_i = 4'(i); bit_val_i = v;
    @(negedge clk); bit_vld_i = 0; sample();
  endtask

  task automatic t_stop();
    stop_i = 1; @(negedge clk); stop_i = 0; sample();
  endtask

  task automatic t_tick();
    tick_no++; idle_tick_i = 1; @(negedge clk); idle_tick_i = 0; sample();
  endtask

  task automatic t_set();
    sleep_set_i = 1; @(negedge clk); sleep_set_i = 0; sample();
  endtask

  task automatic send_char(int d);
    t_start();
    for (int i = 0; i < nb; i++) t_bit(i, d[i]);
    t_stop();
  endtask

  function automatic int ones_run(int d, int n);
    int r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (d[i]) r++;
      else break;
    end
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; start_i = 0; bit_vld_i = 0; bit_val_i = 0; stop_i = 0; idle_tick_i = 0;
    bit_idx_i = '0; ilt_i = 0; wake_sel_i = 0; match_en1_i = 0; match_en2_i = 0;
    nine_bit_i = 0; sleep_set_i = 0; match_cfg_i = 2'b00; match1_i = '0; match2_i = '0;
    clr_mon();
    repeat (3) @(negedge clk);
    chk("R1 sleep_o", int'(sleep_o), 0);
    chk("R1 idle_o", int'(idle_o), 0);
    chk("R1 deliver_o", int'(deliver_o), 0);
    rst_ni = 1;
    @(negedge clk);

    // idle timing and delivery sweep, awake receiver
    for (int n9 = 0; n9 < 2; n9++) begin
      for (int il = 0; il < 2; il++) begin
        nine_bit_i = n9[0]; ilt_i = il[0]; nb = 8 + n9;
        for (int d = 0; d < (1 << nb); d++) begin
          int exp_at;
          clr_mon();
          send_char(d);
          chk("R11/R12 deliver count", dlv_n, 1);
          chk("R11/R12 data", dlv_data, d);
          exp_at = il ? nb + 2 : nb + 2 - ones_run(d, nb) - 1;
          for (int t = 0; t < nb + 4; t++) t_tick();
          if (il != 0) chk("R3 idle tick", idle_at, exp_at);
          else chk("R2 idle tick", idle_at, exp_at);
          chk("R4 idle pulses", idle_n, 1);
        end
      end
    end

    // idle-line wakeup
    nine_bit_i = 0; ilt_i = 0; nb = 8; wake_sel_i = 0; match_cfg_i = 2'b00;
    clr_mon();
    t_set();
    chk("R5 sleep set", int'(sleep_o), 1);
    send_char(9'h03C);
    chk("R10 asleep no delivery", dlv_n, 0);
    for (int t = 1; t <= 10; t++) begin
      t_tick();
      chk("R6 sleep vs idle", int'(sleep_o), (t < 9) ? 1 : 0);
    end
    chk("R6 idle tick", idle_at, 9);
    clr_mon();
    send_char(9'h081);
    chk("R11 awake delivery", dlv_data, 9'h081);

    // set wins over idle wakeup
    clr_mon();
    send_char(0);
    for (int t = 0; t < 8; t++) t_tick();
    sleep_set_i = 1; idle_tick_i = 1;
    @(negedge clk);
    sleep_set_i = 0; idle_tick_i = 0;
    sample();
    chk("R5 set wins", int'(sleep_o), 1);
    chk("R2 idle with set", idle_n, 1);

    // address-mark wakeup
    wake_sel_i = 1; match_cfg_i = 2'b01;
    for (int n9 = 0; n9 < 2; n9++) begin
      nine_bit_i = n9[0]; nb = 8 + n9;
      for (int d = 0; d < (1 << nb); d++) begin
        int msb;
        msb = int'(d[nb-1]);
        clr_mon();
        t_set();
        t_start();
        for (int i = 0; i < nb; i++) begin
          t_bit(i, d[i]);
          if (i == nb - 2) chk("R7 asleep before msb", int'(sleep_o), 1);
          if (i == nb - 1) chk("R7 msb wake", int'(sleep_o), 1 - msb);
        end
        t_stop();
        chk("R8/R10 delivery", dlv_n, msb);
        if (msb != 0) chk("R8 data", dlv_data, d);
        if (msb == 0 && (d % 64) == 0) begin
          for (int t = 0; t < nb + 3; t++) t_tick();
          chk("R7 idle no wake", int'(sleep_o), 1);
        end
      end
    end

    // data-match wakeup, wake_sel_i left at 1 to show the override
    match_cfg_i = 2'b11; match1_i = 9'h15A; match2_i = 9'h0C3;
    nine_bit_i = 0; nb = 8;
    for (int en = 0; en < 4; en++) begin
      match_en1_i = en[0]; match_en2_i = en[1];
      for (int d = 0; d < 256; d++) begin
        int w;
        w = ((en[0] && d == 8'h5A) || (en[1] && d == 8'hC3)) ? 1 : 0;
        clr_mon();
        t_set();
        send_char(d);
        chk("R9/R12 match wake", int'(sleep_o), 1 - w);
        chk("R9/R10 delivery", dlv_n, w);
        if (w != 0) chk("R9 data", dlv_data, d);
      end
    end
    match_en1_i = 1; match_en2_i = 1;
    clr_mon();
    t_set();
    send_char(9'h011);
    for (int t = 0; t < 12; t++) t_tick();
    chk("R9 idle no wake", int'(sleep_o), 1);
    chk("R9 idle seen", idle_n, 1);

    nine_bit_i = 1; nb = 9; match_en2_i = 0;
    clr_mon();
    t_set();
    send_char(9'h05A);
    chk("R12 ninth bit compared", int'(sleep_o), 1);
    send_char(9'h15A);
    chk("R12 nine-bit wake", int'(sleep_o), 0);
    chk("R12 nine-bit data", dlv_data, 9'h15A);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule